// File: doc/BRIEF.md
# Per-CPU Gated Bus Interrupt Receiver

This block takes interrupt messages from a system bus and hands them to processors. A message names a target CPU, gives a source id and carries two 64-bit payload words. Each CPU has a one-entry gate. While the gate is open, the message is taken. The block then latches the source id and both payload words into that CPU's slot, marks the slot busy, and one cycle later pulses a post to that CPU. The post carries a single interrupt vector that software programs and that all CPUs share. While the slot is busy, later messages for that CPU are refused through the ready signal, and the sender retries on its own schedule.

Software uses a small register window to read the latched words and to release the gate. A CPU can reach its slot by index. It can also use a self alias that picks the slot from the requester id of the access, so a CPU can release its own gate without knowing its index. Reads return data one cycle after the request.

Top module: `bus_irq_rx`

## Requirements
- R1: On reset, every busy flag clears, every source and payload latch reads zero, the shared vector reads zero and no post is issued.
- R2: `msg_ready` is low in the same cycle whenever the CPU selected by `msg_cpu` is busy. A refused message changes no busy flag, latch or post.
- R3: An accepted message (`msg_valid` and `msg_ready` high at a clock edge) sets the target's busy flag and latches its source id and both payload words. Other CPUs' slots do not change.
- R4: One cycle after an accept, `post_valid` is high for exactly one cycle, with `post_cpu` equal to the target and `post_vec` equal to the shared vector at the accept edge. `post_valid` is never high at any other time.
- R5: A write to offset 0x000 loads bits 5:0 of the write data into the shared vector. A read of offset 0x000 returns the vector zero-extended.
- R6: A write to offset 0x100 + 8*i sets CPU i's busy flag to bit 5 of the write data. A read there returns the busy flag in bit 5 and the source id in bits 12:8, with all other bits zero.
- R7: Offset 0x008 is the self alias. A write sets the busy flag of CPU `reg_req_id` to bit 5 of the write data. A read returns that CPU's busy word in the R6 format.
- R8: A read of offset 0x200 + 8*i returns CPU i's first payload word. A read of offset 0x300 + 8*i returns its second payload word.
- R9: `reg_rvalid` and `reg_rdata` are valid exactly one cycle after `reg_rd`. Offsets not listed above read as zero, and writes to them change nothing.
- R10: If a busy write that clears CPU i lands in the same cycle as an accept for CPU i, the accept wins and the busy flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Incoming message present |
| msg_ready | output | 1 | Target CPU gate open |
| msg_cpu | input | CPU_W | Target CPU id |
| msg_src | input | SRC_W | Source id of the message |
| msg_d0 | input | 64 | First payload word |
| msg_d1 | input | 64 | Second payload word |
| post_valid | output | 1 | One-cycle interrupt post |
| post_cpu | output | CPU_W | CPU receiving the post |
| post_vec | output | VEC_W | Vector delivered with the post |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 10 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_req_id | input | CPU_W | Id of the CPU issuing the access |
| reg_rdata | output | 64 | Read data, one cycle after the read |
| reg_rvalid | output | 1 | Read data valid |

## Verification
The assertions assume that `msg_cpu` and `reg_req_id` always lie below the CPU count, that `reg_wr` and `reg_rd` are never high in the same cycle, and that register offsets are 8-byte aligned for the indexed windows. The directed stimulus keeps to these assumptions. It uses only CPU ids within range, including the top index 31, and issues one register access per cycle. It also deliberately drives a message together with a clearing busy write for the same CPU, so that the R10 precedence is exercised at the ports.

// File: rtl/rxi_pkg.sv
package rxi_pkg;
    localparam int DW        = 64;
    localparam int OFS_W     = 10;
    localparam int BUSY_BIT  = 5;
    localparam int SRC_LSB   = 8;
    localparam int MAX_CPUS  = 32;

    typedef enum logic [1:0] {
        GRP_CTRL = 2'd0,
        GRP_BUSY = 2'd1,
        GRP_DAT0 = 2'd2,
        GRP_DAT1 = 2'd3
    } grp_e;

    localparam logic [7:0] CTRL_VEC  = 8'h00;
    localparam logic [7:0] CTRL_SELF = 8'h08;

    typedef struct packed {
        grp_e       grp;
        logic [4:0] idx;
        logic [2:0] lane;
    } ofs_t;

    function automatic ofs_t split_ofs(input logic [OFS_W-1:0] a);
        return ofs_t'(a);
    endfunction

    function automatic logic [DW-1:0] busy_word(input logic b, input logic [7:0] src);
        logic [DW-1:0] w;
        w = '0;
        w[BUSY_BIT] = b;
        w[SRC_LSB +: 8] = src;
        return w;
    endfunction
endpackage

// File: rtl/rxi_slot.sv
module rxi_slot
    import rxi_pkg::*;
#(
    parameter int SRC_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [SRC_W-1:0] src_i,
    input  logic [DW-1:0]    d0_i,
    input  logic [DW-1:0]    d1_i,
    input  logic             bw_en,
    input  logic             bw_val,
    output logic             busy_o,
    output logic [SRC_W-1:0] src_o,
    output logic [DW-1:0]    d0_o,
    output logic [DW-1:0]    d1_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            src_o  <= '0;
            d0_o   <= '0;
            d1_o   <= '0;
        end else begin
            // an accept takes precedence over a software busy write
            if (take)
                busy_o <= 1'b1;
            else if (bw_en)
                busy_o <= bw_val;
            if (take) begin
                src_o <= src_i;
                d0_o  <= d0_i;
                d1_o  <= d1_i;
            end
        end
    end
endmodule

// File: rtl/rxi_regs.sv
module rxi_regs
    import rxi_pkg::*;
#(
    parameter int NUM_CPUS = 32,
    parameter int SRC_W    = 5,
    parameter int VEC_W    = 6,
    localparam int CPU_W   = $clog2(NUM_CPUS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr,
    input  logic                           rd,
    input  logic [OFS_W-1:0]               addr,
    input  logic [DW-1:0]                  wdata,
    input  logic [CPU_W-1:0]               req_id,
    input  logic [NUM_CPUS-1:0]            busy_i,
    input  logic [NUM_CPUS-1:0][SRC_W-1:0] src_i,
    input  logic [NUM_CPUS-1:0][DW-1:0]    d0_i,
    input  logic [NUM_CPUS-1:0][DW-1:0]    d1_i,
    output logic [VEC_W-1:0]               vec_o,
    output logic [NUM_CPUS-1:0]            bw_en_o,
    output logic                           bw_val_o,
    output logic [DW-1:0]                  rdata_o,
    output logic                           rvalid_o
);
    ofs_t             o;
    logic [7:0]       low;
    logic [CPU_W-1:0] sel;
    logic             in_rng;
    logic             hit_vec, hit_self;
    logic [DW-1:0]    rnext;

    assign o        = split_ofs(addr);
    assign low      = {o.idx, o.lane};
    assign sel      = o.idx[CPU_W-1:0];
    assign in_rng   = (o.lane == 3'd0) && (32'(o.idx) < NUM_CPUS);
    assign hit_vec  = (o.grp == GRP_CTRL) && (low == CTRL_VEC);
    assign hit_self = (o.grp == GRP_CTRL) && (low == CTRL_SELF);
    assign bw_val_o = wdata[BUSY_BIT];

    for (genvar i = 0; i < NUM_CPUS; i++) begin : g_wdec
        assign bw_en_o[i] = wr && ((o.grp == GRP_BUSY && in_rng && sel == CPU_W'(i)) ||
                                   (hit_self && req_id == CPU_W'(i)));
    end

    always_comb begin
        rnext = '0;
        unique case (o.grp)
            GRP_CTRL: begin
                if (hit_vec)
                    rnext = DW'(vec_o);
                else if (hit_self)
                    rnext = busy_word(busy_i[req_id], 8'(src_i[req_id]));
            end
            GRP_BUSY: if (in_rng) rnext = busy_word(busy_i[sel], 8'(src_i[sel]));
            GRP_DAT0: if (in_rng) rnext = d0_i[sel];
            GRP_DAT1: if (in_rng) rnext = d1_i[sel];
            default:  rnext = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_o    <= '0;
            rdata_o  <= '0;
            rvalid_o <= 1'b0;
        end else begin
            if (wr && hit_vec)
                vec_o <= wdata[VEC_W-1:0];
            rvalid_o <= rd;
            if (rd)
                rdata_o <= rnext;
        end
    end
endmodule

// File: rtl/bus_irq_rx.sv
module bus_irq_rx
    import rxi_pkg::*;
#(
    parameter int NUM_CPUS = MAX_CPUS,
    parameter int SRC_W    = 5,
    parameter int VEC_W    = 6,
    localparam int CPU_W   = $clog2(NUM_CPUS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             msg_valid,
    output logic             msg_ready,
    input  logic [CPU_W-1:0] msg_cpu,
    input  logic [SRC_W-1:0] msg_src,
    input  logic [DW-1:0]    msg_d0,
    input  logic [DW-1:0]    msg_d1,
    output logic             post_valid,
    output logic [CPU_W-1:0] post_cpu,
    output logic [VEC_W-1:0] post_vec,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [OFS_W-1:0] reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic [CPU_W-1:0] reg_req_id,
    output logic [DW-1:0]    reg_rdata,
    output logic             reg_rvalid
);
    logic [NUM_CPUS-1:0]            busy_vec;
    logic [NUM_CPUS-1:0][SRC_W-1:0] src_arr;
    logic [NUM_CPUS-1:0][DW-1:0]    d0_arr, d1_arr;
    logic [NUM_CPUS-1:0]            bw_en;
    logic                           bw_val;
    logic [VEC_W-1:0]               vec_q;
    logic                           accept;

    assign msg_ready = !busy_vec[msg_cpu];
    assign accept    = msg_valid && msg_ready;

    for (genvar i = 0; i < NUM_CPUS; i++) begin : g_slot
        rxi_slot #(.SRC_W(SRC_W)) slot_i (
            .clk    (clk),
            .rst    (rst),
            .take   (accept && msg_cpu == CPU_W'(i)),
            .src_i  (msg_src),
            .d0_i   (msg_d0),
            .d1_i   (msg_d1),
            .bw_en  (bw_en[i]),
            .bw_val (bw_val),
            .busy_o (busy_vec[i]),
            .src_o  (src_arr[i]),
            .d0_o   (d0_arr[i]),
            .d1_o   (d1_arr[i])
        );
    end

    rxi_regs #(.NUM_CPUS(NUM_CPUS), .SRC_W(SRC_W), .VEC_W(VEC_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .req_id   (reg_req_id),
        .busy_i   (busy_vec),
        .src_i    (src_arr),
        .d0_i     (d0_arr),
        .d1_i     (d1_arr),
        .vec_o    (vec_q),
        .bw_en_o  (bw_en),
        .bw_val_o (bw_val),
        .rdata_o  (reg_rdata),
        .rvalid_o (reg_rvalid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            post_valid <= 1'b0;
            post_cpu   <= '0;
            post_vec   <= '0;
        end else begin
            post_valid <= accept;
            if (accept) begin
                post_cpu <= msg_cpu;
                post_vec <= vec_q;
            end
        end
    end
endmodule

// File: rtl/bus_irq_rx_chk.sv
module bus_irq_rx_chk
    import rxi_pkg::*;
#(
    parameter int NUM_CPUS = 32,
    parameter int VEC_W    = 6,
    localparam int CPU_W   = $clog2(NUM_CPUS)
) (
    input logic                clk,
    input logic                rst,
    input logic                msg_valid,
    input logic                msg_ready,
    input logic [CPU_W-1:0]    msg_cpu,
    input logic                post_valid,
    input logic [CPU_W-1:0]    post_cpu,
    input logic [VEC_W-1:0]    post_vec,
    input logic                reg_wr,
    input logic                reg_rd,
    input logic [OFS_W-1:0]    reg_addr,
    input logic [DW-1:0]       reg_wdata,
    input logic                reg_rvalid,
    input logic [NUM_CPUS-1:0] busy_vec,
    input logic [VEC_W-1:0]    vec_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (busy_vec == '0 && !post_valid && vec_q == '0));

    assert_refuse_no_change_R2: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready && !reg_wr) |=> $stable(busy_vec));

    assert_accept_sets_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready) |=> busy_vec[$past(msg_cpu)]);

    assert_post_follows_R4: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready) |=>
            (post_valid && post_cpu == $past(msg_cpu) && post_vec == $past(vec_q)));

    assert_post_only_R4: assert property (@(posedge clk) disable iff (rst)
        post_valid |-> $past(msg_valid && msg_ready));

    assert_vec_load_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == '0) |=> vec_q == $past(reg_wdata[VEC_W-1:0]));

    assert_read_latency_R9: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> reg_rvalid);

    assert_no_spurious_rvalid_R9: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> !reg_rvalid);

    assert_accept_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready && reg_wr && !reg_wdata[BUSY_BIT]) |=>
            busy_vec[$past(msg_cpu)]);
endmodule

bind bus_irq_rx bus_irq_rx_chk #(.NUM_CPUS(NUM_CPUS), .VEC_W(VEC_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_cpu    (msg_cpu),
    .post_valid (post_valid),
    .post_cpu   (post_cpu),
    .post_vec   (post_vec),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rvalid (reg_rvalid),
    .busy_vec   (busy_vec),
    .vec_q      (vec_q)
);

// File: tb/bus_irq_rx_tb_top.sv
module bus_irq_rx_tb_top;
    localparam int CPU_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             msg_valid = 1'b0;
    logic             msg_ready;
    logic [CPU_W-1:0] msg_cpu = '0;
    logic [4:0]       msg_src = '0;
    logic [63:0]      msg_d0 = '0, msg_d1 = '0;
    logic             post_valid;
    logic [CPU_W-1:0] post_cpu;
    logic [5:0]       post_vec;
    logic             reg_wr = 1'b0, reg_rd = 1'b0;
    logic [9:0]       reg_addr = '0;
    logic [63:0]      reg_wdata = '0;
    logic [CPU_W-1:0] reg_req_id = '0;
    logic [63:0]      reg_rdata;
    logic             reg_rvalid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bus_irq_rx dut_i (
        .clk(clk), .rst(rst),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_cpu(msg_cpu),
        .msg_src(msg_src), .msg_d0(msg_d0), .msg_d1(msg_d1),
        .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_req_id(reg_req_id),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [9:0] a, input logic [63:0] d, input logic [4:0] rq);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_req_id = rq;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [9:0] a, input logic [4:0] rq, output logic [63:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a; reg_req_id = rq;
        @(negedge clk);
        reg_rd = 1'b0;
        check("R9 rvalid", 64'(reg_rvalid), 64'd1);
        d = reg_rdata;
    endtask

    // offers one message; checks post one cycle later against expectation
    task automatic send(input logic [4:0] cpu, input logic [4:0] src,
                        input logic [63:0] d0, input logic [63:0] d1,
                        input bit exp_take, input logic [5:0] exp_vec);
        @(negedge clk);
        msg_valid = 1'b1; msg_cpu = cpu; msg_src = src; msg_d0 = d0; msg_d1 = d1;
        #1;
        check("R2 ready", 64'(msg_ready), 64'(exp_take));
        @(negedge clk);
        msg_valid = 1'b0;
        check("R4 post_valid", 64'(post_valid), 64'(exp_take));
        if (exp_take) begin
            check("R4 post_cpu", 64'(post_cpu), 64'(cpu));
            check("R4 post_vec", 64'(post_vec), 64'(exp_vec));
        end
        @(negedge clk);
        check("R4 single pulse", 64'(post_valid), 64'd0);
    endtask

    function automatic logic [63:0] bw(input bit b, input logic [4:0] s);
        return (64'(b) << 5) | (64'(s) << 8);
    endfunction

    task automatic t_reset();
        logic [63:0] d;
        check("R1 post", 64'(post_valid), 64'd0);
        check("R1 ready", 64'(msg_ready), 64'd1);
        reg_read(10'h100, 5'd0, d); check("R1 busy0", d, 64'd0);
        reg_read(10'h000, 5'd0, d); check("R1 vec", d, 64'd0);
        reg_read(10'h218, 5'd0, d); check("R1 data0 cpu3", d, 64'd0);
    endtask

    task automatic t_vector();
        logic [63:0] d;
        reg_write(10'h000, 64'hFFC5, 5'd0);
        reg_read(10'h000, 5'd0, d); check("R5 vec low bits", d, 64'h05);
        reg_write(10'h000, 64'h2A, 5'd0);
        reg_read(10'h000, 5'd0, d); check("R5 vec", d, 64'h2A);
    endtask

    task automatic t_accept();
        logic [63:0] d;
        send(5'd4, 5'h13, 64'hDEAD_BEEF_0123_4567, 64'h8899_AABB_CCDD_EEFF, 1'b1, 6'h2A);
        reg_read(10'h120, 5'd0, d); check("R3 R6 busy word cpu4", d, bw(1'b1, 5'h13));
        reg_read(10'h220, 5'd0, d); check("R3 R8 data0 cpu4", d, 64'hDEAD_BEEF_0123_4567);
        reg_read(10'h320, 5'd0, d); check("R3 R8 data1 cpu4", d, 64'h8899_AABB_CCDD_EEFF);
        reg_read(10'h128, 5'd0, d); check("R3 cpu5 untouched", d, 64'd0);
        send(5'd31, 5'h1F, 64'h1, 64'h2, 1'b1, 6'h2A);
        reg_read(10'h1F8, 5'd0, d); check("R3 cpu31 busy", d, bw(1'b1, 5'h1F));
        reg_read(10'h3F8, 5'd0, d); check("R8 cpu31 data1", d, 64'h2);
    endtask

    task automatic t_refuse();
        logic [63:0] d;
        send(5'd4, 5'h07, 64'h5555, 64'h6666, 1'b0, 6'h0);
        reg_read(10'h220, 5'd0, d); check("R2 data kept", d, 64'hDEAD_BEEF_0123_4567);
        reg_read(10'h120, 5'd0, d); check("R2 source kept", d, bw(1'b1, 5'h13));
    endtask

    task automatic t_clear_idx();
        logic [63:0] d;
        reg_write(10'h120, 64'h0, 5'd0);
        reg_read(10'h120, 5'd0, d); check("R6 cleared", d, bw(1'b0, 5'h13));
        reg_write(10'h000, 64'h11, 5'd0);
        send(5'd4, 5'h02, 64'hA, 64'hB, 1'b1, 6'h11);
        reg_read(10'h220, 5'd0, d); check("R6 new data", d, 64'hA);
    endtask

    task automatic t_alias();
        logic [63:0] d;
        send(5'd7, 5'h09, 64'h77, 64'h78, 1'b1, 6'h11);
        reg_read(10'h008, 5'd7, d); check("R7 alias read", d, bw(1'b1, 5'h09));
        reg_write(10'h008, 64'h0, 5'd7);
        reg_read(10'h138, 5'd0, d); check("R7 alias clear", d, bw(1'b0, 5'h09));
        reg_write(10'h008, 64'h20, 5'd9);
        reg_read(10'h148, 5'd0, d); check("R7 alias set cpu9", d, bw(1'b1, 5'h00));
        send(5'd9, 5'h01, 64'h0, 64'h0, 1'b0, 6'h0);
        reg_write(10'h148, 64'h0, 5'd0);
    endtask

    task automatic t_race();
        logic [63:0] d;
        @(negedge clk);
        msg_valid = 1'b1; msg_cpu = 5'd12; msg_src = 5'h0C; msg_d0 = 64'hC0; msg_d1 = 64'hC1;
        reg_wr = 1'b1; reg_addr = 10'h160; reg_wdata = 64'h0; reg_req_id = 5'd0;
        @(negedge clk);
        msg_valid = 1'b0; reg_wr = 1'b0;
        reg_read(10'h160, 5'd0, d); check("R10 accept wins", d, bw(1'b1, 5'h0C));
    endtask

    task automatic t_unmapped();
        logic [63:0] d;
        reg_write(10'h010, 64'hFFFF_FFFF_FFFF_FFFF, 5'd0);
        reg_read(10'h010, 5'd0, d); check("R9 unmapped read", d, 64'd0);
        reg_read(10'h000, 5'd0, d); check("R9 vec untouched", d, 64'h11);
        @(negedge clk);
        check("R9 rvalid drops", 64'(reg_rvalid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_vector();
        t_accept();
        t_refuse();
        t_clear_idx();
        t_alias();
        t_race();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1-flow actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule